// File: doc/BRIEF.md
# Multicycle Accumulator Processor

This block is a small stored-program processor with one accumulator and a single shared memory port. Each instruction runs as a sequence of clocked register transfers. A control state machine moves addresses into a memory address register and collects returned words in a memory data register. It keeps the fetched instruction in an instruction register. Results are written to the accumulator and to a three-flag status register. Code and data share one memory. Instruction fetch, operand reads and stores all use the same address, read-strobe and write-strobe lines.

The instruction word is split into an operation code and a memory address. The instruction set has addition and subtraction with a memory operand, bitwise AND and OR, load, store, an unconditional jump and a halt instruction. Every other operation code does nothing except use up its fetch. Memory is assumed synchronous: a word requested in one cycle shows up on the read-data input in the next cycle. The status output shows the current overflow, carry and zero flags, so a testbench or a neighbouring block can see the outcome of the last arithmetic or logic step.

Top module: `acc_cpu_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter, accumulator, address register, data register and flags to zero. The first access after reset is an instruction read at address 0, with its read strobe high in the first cycle after reset falls.
- R2: Each fetch copies the program counter into the address register and then issues a read at that address. Instructions that do not jump are fetched from consecutive addresses.
- R3: An instruction is 16 bits, with the operation code in bits 15:12 and the operand address in bits 11:0. The codes are 0 halt, 1 add, 2 subtract, 3 AND, 4 OR, 5 load, 6 store and 7 jump.
- R4: Add, subtract, AND, OR and load issue a second read at the operand address before the accumulator changes.
- R5: Add and subtract put ACC+M and ACC−M, taken modulo 2^16, into the accumulator.
- R6: AND and OR put the bitwise result of the accumulator and M into the accumulator. Load copies M into it.
- R7: Store issues a single write of the accumulator value at the operand address and does no operand read. Read and write strobes are never high together.
- R8: A jump issues no operand access, and the next fetch comes from the operand address.
- R9: Status bit 0 is zero (result is 0). Bit 1 is carry: carry-out for add, borrow (ACC < M unsigned) for subtract. Bit 2 is signed overflow. AND, OR and load update zero and clear carry and overflow.
- R10: Store, jump, halt and the no-op codes leave the flags unchanged.
- R11: Codes 8 to 15 perform no memory access beyond their own fetch and leave the accumulator unchanged. Execution goes on at the next address.
- R12: After a halt is fetched, no strobe goes high again until reset.
- R13: The gap from one strobe to the next is fixed. From a fetch to its operand access it is 3 cycles. From an operand read to the next fetch it is 3 cycles. From a store write to the next fetch it is 2 cycles. From a jump or no-op fetch to the next fetch it is 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory address, driven from the address register |
| mem_rd | output | 1 | Read strobe; data returns one cycle later |
| mem_wr | output | 1 | Write strobe for a store |
| mem_wdata | output | 16 | Write data, driven from the data register |
| mem_rdata | input | 16 | Read data from memory |
| status | output | 3 | Flags: bit 2 overflow, bit 1 carry, bit 0 zero |

## Verification
The accumulator write-back and the flag update happen on the same clock edge, and both come from one ALU result. The programs drive that edge with sums that wrap to zero with a carry, with signed overflow in both directions, with a subtract that borrows, and with a logic operation that comes right after a carry. After each case, a store brings the accumulator value out on the write port. The status pins are read once the program halts, after stores, jumps and no-ops that must not disturb them. A scoreboard model of the instruction set predicts every memory access with its cycle gap. It also predicts the final flags.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPC_W = 4;

    typedef logic [OPC_W-1:0] opc_t;

    // R3: operation code values
    localparam opc_t OPC_HALT  = 4'd0;
    localparam opc_t OPC_ADD   = 4'd1;
    localparam opc_t OPC_SUB   = 4'd2;
    localparam opc_t OPC_AND   = 4'd3;
    localparam opc_t OPC_OR    = 4'd4;
    localparam opc_t OPC_LOAD  = 4'd5;
    localparam opc_t OPC_STORE = 4'd6;
    localparam opc_t OPC_JUMP  = 4'd7;

    typedef enum logic [2:0] {
        ST_FETCH_ADDR,
        ST_FETCH_WAIT,
        ST_DECODE,
        ST_OPER_ADDR,
        ST_OPER_WAIT,
        ST_EXECUTE,
        ST_HALTED
    } cpu_state_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_PASS
    } alu_op_e;

    // bit 2 overflow, bit 1 carry, bit 0 zero
    typedef struct packed {
        logic ovf;
        logic cry;
        logic zro;
    } flags_t;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_opnd;
        logic pc_inc;
        logic pc_jump;
        logic mdr_from_mem;
        logic mdr_from_acc;
        logic cir_load;
        logic acc_load;
        logic mem_rd;
        logic mem_wr;
    } ctrl_t;

    function automatic logic needs_operand(opc_t op);
        return (op >= OPC_ADD) && (op <= OPC_STORE);
    endfunction

    function automatic alu_op_e alu_select(opc_t op);
        case (op)
            OPC_ADD: return ALU_ADD;
            OPC_SUB: return ALU_SUB;
            OPC_AND: return ALU_AND;
            OPC_OR:  return ALU_OR;
            default: return ALU_PASS;
        endcase
    endfunction

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output flags_t       f
);

    logic [W:0] wide;

    always_comb begin
        wide  = '0;
        f     = '0;
        case (op)
            ALU_ADD: begin
                wide  = {1'b0, a} + {1'b0, b};
                f.cry = wide[W];
                f.ovf = (a[W-1] == b[W-1]) && (wide[W-1] != a[W-1]);
            end
            ALU_SUB: begin
                wide  = {1'b0, a} - {1'b0, b};
                f.cry = wide[W];
                f.ovf = (a[W-1] != b[W-1]) && (wide[W-1] != a[W-1]);
            end
            ALU_AND:  wide = {1'b0, a & b};
            ALU_OR:   wide = {1'b0, a | b};
            default:  wide = {1'b0, b};
        endcase
        y     = wide[W-1:0];
        f.zro = (y == '0);
    end

    // R9
    always_comb begin
        if (op == ALU_ADD && f.cry) begin
            add_carry_wrap_chk: assert (y < a);
        end
    end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  opc_t       dec_opc,
    output cpu_state_e state,
    output ctrl_t      ctl
);

    cpu_state_e nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH_ADDR;
        else     state <= nxt;
    end

    always_comb begin
        ctl = '0;
        nxt = state;
        case (state)
            ST_FETCH_ADDR: begin
                ctl.mar_from_pc = 1'b1;
                nxt = ST_FETCH_WAIT;
            end
            ST_FETCH_WAIT: begin
                ctl.mem_rd = 1'b1;
                ctl.pc_inc = 1'b1;
                nxt = ST_DECODE;
            end
            ST_DECODE: begin
                // the returned word is latched into MDR and CIR while its fields are decoded
                ctl.mdr_from_mem = 1'b1;
                ctl.cir_load     = 1'b1;
                if (dec_opc == OPC_HALT) begin
                    nxt = ST_HALTED;
                end else if (dec_opc == OPC_JUMP) begin
                    ctl.pc_jump = 1'b1;
                    nxt = ST_FETCH_ADDR;
                end else if (needs_operand(dec_opc)) begin
                    nxt = ST_OPER_ADDR;
                end else begin
                    nxt = ST_FETCH_ADDR;
                end
            end
            ST_OPER_ADDR: begin
                ctl.mar_from_opnd = 1'b1;
                ctl.mdr_from_acc  = (dec_opc == OPC_STORE);
                nxt = ST_OPER_WAIT;
            end
            ST_OPER_WAIT: begin
                if (dec_opc == OPC_STORE) begin
                    ctl.mem_wr = 1'b1;
                    nxt = ST_FETCH_ADDR;
                end else begin
                    ctl.mem_rd = 1'b1;
                    nxt = ST_EXECUTE;
                end
            end
            ST_EXECUTE: begin
                ctl.mdr_from_mem = 1'b1;
                ctl.acc_load     = 1'b1;
                nxt = ST_FETCH_ADDR;
            end
            ST_HALTED: nxt = ST_HALTED;
            default:   nxt = ST_FETCH_ADDR;
        endcase
    end

    // R12
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALTED) |=> (state == ST_HALTED));

    // R13
    store_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.mem_wr |=> (state == ST_FETCH_ADDR));

    // R4
    exec_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXECUTE) |-> $past(ctl.mem_rd));

endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
    import acc_cpu_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = WORD_W - OPC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctl,
    input  cpu_state_e        state,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output opc_t              dec_opc,
    output flags_t            flags
);

    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] mar;
    logic [WORD_W-1:0] mdr;
    logic [WORD_W-1:0] cir;
    logic [WORD_W-1:0] acc;

    logic [WORD_W-1:0] dec_word;
    logic [ADDR_W-1:0] opnd;
    logic [WORD_W-1:0] alu_y;
    flags_t            alu_f;

    // R3: decode the word in flight during DECODE, the held instruction afterwards
    assign dec_word = ctl.cir_load ? mem_rdata : cir;
    assign dec_opc  = dec_word[WORD_W-1 -: OPC_W];
    assign opnd     = dec_word[ADDR_W-1:0];

    // the ALU operand is the word that is being captured into MDR
    acc_cpu_alu #(.W(WORD_W)) u_alu (
        .op (alu_select(dec_opc)),
        .a  (acc),
        .b  (mem_rdata),
        .y  (alu_y),
        .f  (alu_f)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= '0;
            mar   <= '0;
            mdr   <= '0;
            cir   <= '0;
            acc   <= '0;
            flags <= '0;
        end else begin
            if (ctl.mar_from_pc)        mar <= pc;
            else if (ctl.mar_from_opnd) mar <= opnd;

            if (ctl.pc_jump)     pc <= opnd;
            else if (ctl.pc_inc) pc <= pc + 1'b1;

            if (ctl.mdr_from_mem)      mdr <= mem_rdata;
            else if (ctl.mdr_from_acc) mdr <= acc;

            if (ctl.cir_load) cir <= mem_rdata;

            if (ctl.acc_load) begin
                acc   <= alu_y;
                flags <= alu_f;
            end
        end
    end

    assign mem_addr  = mar;
    assign mem_wdata = mdr;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (pc == '0 && acc == '0 && mar == '0 && mdr == '0 && flags == '0));

    // R2
    fetch_mar_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH_ADDR) |=> (mar == $past(pc)));

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH_WAIT) |=> (pc == $past(pc) + 1'b1));

    // R8
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECODE && dec_opc == OPC_JUMP) |=> (pc == $past(opnd)));

    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_EXECUTE) |=> $stable(flags));

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter int  WORD_W = 16,
    localparam int ADDR_W = WORD_W - OPC_W
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [2:0]        status
);

    cpu_state_e state;
    ctrl_t      ctl;
    opc_t       dec_opc;
    flags_t     flags;

    acc_cpu_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .dec_opc (dec_opc),
        .state   (state),
        .ctl     (ctl)
    );

    acc_cpu_dp #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .state     (state),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .dec_opc   (dec_opc),
        .flags     (flags)
    );

    assign mem_rd = ctl.mem_rd;
    assign mem_wr = ctl.mem_wr;
    assign status = flags;

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

endmodule

// File: tb/acc_cpu_core_test.sv
module acc_cpu_core_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int AW = 12;
    localparam int MEM_N = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] mem_addr;
    logic          mem_rd, mem_wr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [2:0]    status;

    logic [DW-1:0] mem [MEM_N];
    int ref_m [int];

    typedef struct {
        bit    wr;
        int    addr;
        int    data;
        int    gap;
        string tag;
    } item_t;

    item_t exp_q[$];

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    int last_cyc = 0;
    int exp_status = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // synchronous memory, one cycle read latency
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_wr) mem[mem_addr] <= mem_wdata;
    end

    acc_cpu_core uut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .status    (status)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every strobe
    always @(negedge clk) begin
        item_t e;
        if (!rst && (mem_rd || mem_wr)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R12", "access after halt", int'(mem_addr), -1);
            end else begin
                e = exp_q.pop_front();
                check(mem_wr == e.wr, e.tag, "access kind", int'(mem_wr), int'(e.wr));
                check(int'(mem_addr) == e.addr, e.tag, "address", int'(mem_addr), e.addr);
                if (e.wr)
                    check(int'(mem_wdata) == e.data, "R7", "store data", int'(mem_wdata), e.data);
                check(cyc - last_cyc == e.gap, "R13", "strobe gap", cyc - last_cyc, e.gap);
            end
            last_cyc = cyc;
        end
    end

    function automatic int enc(int op, int a);
        return ((op & 15) << 12) | (a & 'hFFF);   // R3 field layout
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < MEM_N; i++) mem[i] = '0;
        ref_m.delete();
    endtask

    task automatic poke(int a, int v);
        mem[a] = v[DW-1:0];
        ref_m[a] = v & 'hFFFF;
    endtask

    // instruction-level model of the requirements
    task automatic predict();
        int pc = 0, acc = 0, z = 0, c = 0, v = 0, gap = 1;
        string tag = "R1";
        for (int step = 0; step < 500; step++) begin
            int w, op, opd, b, r;
            w   = ref_m.exists(pc) ? ref_m[pc] : 0;
            op  = (w >> 12) & 15;
            opd = w & 'hFFF;
            exp_q.push_back('{1'b0, pc, 0, gap, tag});
            pc  = (pc + 1) & 'hFFF;
            gap = 3;
            tag = "R2";
            if (op == 0) break;
            if (op >= 1 && op <= 5) begin
                b = ref_m.exists(opd) ? ref_m[opd] : 0;
                exp_q.push_back('{1'b0, opd, 0, 3, "R4"});
                c = 0; v = 0;
                case (op)
                    1: begin
                        r = acc + b;
                        c = (r >> 16) & 1;
                        r = r & 'hFFFF;
                        v = ((~(acc ^ b)) & (acc ^ r) & 'h8000) != 0;
                    end
                    2: begin
                        r = (acc - b) & 'hFFFF;
                        c = (acc < b);
                        v = ((acc ^ b) & (acc ^ r) & 'h8000) != 0;
                    end
                    3: r = acc & b;
                    4: r = acc | b;
                    default: r = b;
                endcase
                z = (r == 0);
                acc = r;
            end else if (op == 6) begin
                exp_q.push_back('{1'b1, opd, acc, 3, "R7"});
                ref_m[opd] = acc;
                gap = 2;
            end else if (op == 7) begin
                pc  = opd;
                tag = "R8";
            end else begin
                tag = "R11";
            end
        end
        exp_status = (v << 2) | (c << 1) | z;
    endtask

    task automatic run_prog(string name);
        int t = 0;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(status == 3'b000, "R1", {name, " status in reset"}, int'(status), 0);
        check(!mem_rd && !mem_wr, "R1", {name, " strobes in reset"},
              int'({mem_rd, mem_wr}), 0);
        predict();
        last_cyc = cyc;
        rst = 1'b0;
        while (exp_q.size() != 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R12", {name, " accesses left"}, exp_q.size(), 0);
        check(int'(status) == exp_status, "R9", {name, " final flags"}, int'(status), exp_status);
        exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R12", "watchdog expired", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        // program 1: the worked trace, ADD at 30 with ACC=7 and M[50]=5
        clear_mem();
        poke(0, enc(5, 40));
        poke(1, enc(7, 30));
        poke(30, enc(1, 50));
        poke(31, enc(6, 60));
        poke(32, enc(0, 0));
        poke(40, 7);
        poke(50, 5);
        run_prog("trace");
        check(int'(mem[60]) == 12, "R5", "7+5", int'(mem[60]), 12);

        // program 2: borrow, overflow, wrap to zero, then flag-neutral ops
        clear_mem();
        poke(0, enc(5, 100));
        poke(1, enc(2, 101));
        poke(2, enc(6, 120));
        poke(3, enc(5, 102));
        poke(4, enc(1, 103));
        poke(5, enc(6, 121));
        poke(6, enc(5, 104));
        poke(7, enc(1, 105));
        poke(8, enc(6, 122));
        poke(9, enc(9, 0));
        poke(10, enc(7, 12));
        poke(11, enc(6, 123));
        poke(12, enc(0, 0));
        poke(100, 'h0003);
        poke(101, 'h0005);
        poke(102, 'h7FFF);
        poke(103, 'h0001);
        poke(104, 'hFFFF);
        poke(105, 'h0001);
        poke(122, 'h5555);
        run_prog("arith");
        check(int'(mem[120]) == 'hFFFE, "R5", "3-5", int'(mem[120]), 'hFFFE);
        check(int'(mem[121]) == 'h8000, "R5", "7FFF+1", int'(mem[121]), 'h8000);
        check(int'(mem[122]) == 'h0000, "R5", "FFFF+1", int'(mem[122]), 0);
        check(int'(mem[123]) == 'h0000, "R8", "skipped store", int'(mem[123]), 0);
        check(status == 3'b011, "R10", "flags kept past store/jump/no-op", int'(status), 3);

        // program 3: logic ops, carry cleared by OR
        clear_mem();
        poke(0, enc(5, 200));
        poke(1, enc(3, 201));
        poke(2, enc(6, 210));
        poke(3, enc(4, 202));
        poke(4, enc(6, 211));
        poke(5, enc(1, 206));
        poke(6, enc(6, 212));
        poke(7, enc(4, 202));
        poke(8, 'hF123);
        poke(9, enc(0, 0));
        poke(200, 'h0F0F);
        poke(201, 'h00FF);
        poke(202, 'hF000);
        poke(206, 'h0FF1);
        poke(212, 'hAAAA);
        run_prog("logic");
        check(int'(mem[210]) == 'h000F, "R6", "AND", int'(mem[210]), 'h000F);
        check(int'(mem[211]) == 'hF00F, "R6", "OR", int'(mem[211]), 'hF00F);
        check(int'(mem[212]) == 'h0000, "R5", "carry wrap", int'(mem[212]), 0);
        check(status == 3'b000, "R9", "logic clears carry", int'(status), 0);
        check(int'(mem['h123]) == 0, "R11", "no-op operand untouched", int'(mem['h123]), 0);

        // program 4: accumulator cleared by reset, subtract overflow
        clear_mem();
        poke(0, enc(6, 311));
        poke(1, enc(5, 300));
        poke(2, enc(2, 301));
        poke(3, enc(6, 310));
        poke(4, enc(0, 0));
        poke(300, 'h8000);
        poke(301, 'h0001);
        poke(311, 'hAAAA);
        run_prog("ovf");
        check(int'(mem[311]) == 0, "R1", "ACC after reset", int'(mem[311]), 0);
        check(int'(mem[310]) == 'h7FFF, "R5", "8000-1", int'(mem[310]), 'h7FFF);
        check(status == 3'b100, "R9", "subtract overflow", int'(status), 4);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule